// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Carry and Overflow Flags

This unit sits in the integer datapath of a processor core. It performs three operations on a 64-bit operand: a logical left shift, an arithmetic right shift, and a rotate right. The active operand width is selectable as 8, 16, 32 or 64 bits. All bits above the active width are ignored on the way in and forced to zero on the way out. The most significant bit of the active width acts as the sign and top bit for every flag rule.

The count is reduced to the range the architecture allows. Narrow sizes keep only its low five bits. The 64-bit size keeps six. A reduced count of zero leaves the flag state alone. In that case the flag-write enable stays low, and the carry and overflow outputs echo the current flag values, which the caller supplies as inputs.

For nonzero counts, the carry output holds the last bit that left the operand. The overflow output follows a separate rule for each operation when the count is one. For larger counts, overflow is architecturally undefined. The unit then keeps the incoming overflow value and raises a marker for this case. The result path is combinational. An optional output register, selected by a parameter and enabled by default, adds one cycle of latency.

Top module: `shrot_unit`

## Requirements
- R1: The count is reduced before use. Size codes 0, 1 and 2 (8, 16 and 32 bits) keep `count[4:0]`. Size code 3 (64 bits) keeps `count[5:0]`. All higher count bits have no effect.
- R2: When the reduced count is 0, `flag_we` is 0 and `of_undefined` is 0. `cf_out` equals `prev_cf`, `of_out` equals `prev_of`, and `result` equals the active-width bits of `operand`.
- R3: For `op_sel` 0 (left shift), vacated low bits are filled with 0. `cf_out` is the last bit shifted out past the top of the active width.
- R4: For `op_sel` 1 (arithmetic right shift), the sign bit is copied into vacated high bits. `cf_out` is the last bit shifted out of bit 0. Example: 0xFFFFFFF5 at 32 bits shifted by 2 gives 0xFFFFFFFD.
- R5: For `op_sel` 2 (rotate right), the rotation amount is the reduced count modulo the active width. `cf_out` equals the result's top active bit, and the flags are written even when the rotation amount is 0.
- R6: For a left shift by 1, `of_out` is `cf_out` XOR the result's top active bit.
- R7: For an arithmetic right shift by 1, `of_out` is 0.
- R8: For a rotate right by 1, `of_out` is the XOR of the result's two top active bits.
- R9: When the reduced count is greater than 1, `flag_we` is 1, `of_undefined` is 1, and `of_out` equals `prev_of`. `of_undefined` is never 1 while `flag_we` is 0.
- R10: Result bits at and above the active width are 0.
- R11: When the reduced count is at or above the active width, a left shift gives 0, with `cf_out` equal to operand bit 0 at a count equal to the width and 0 beyond it. An arithmetic right shift gives all sign copies, with `cf_out` equal to the sign.
- R12: `op_sel` 3 is a no-operation. `result` is the active-width operand, `flag_we` is 0, and the flags echo `prev_cf` and `prev_of`.
- R13: With the output register enabled, `out_valid` and the outputs appear one cycle after `in_valid`. Reset clears `out_valid`, `result` and all flag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 2 | 0 left shift, 1 arithmetic right, 2 rotate right, 3 no-op |
| size_sel | input | 2 | 0: 8, 1: 16, 2: 32, 3: 64 bits |
| operand | input | 64 | Value to shift or rotate |
| count | input | 8 | Raw shift count |
| prev_cf | input | 1 | Current carry flag |
| prev_of | input | 1 | Current overflow flag |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Shifted or rotated value, zero above active width |
| cf_out | output | 1 | Carry flag value |
| of_out | output | 1 | Overflow flag value |
| flag_we | output | 1 | Flag write enable |
| of_undefined | output | 1 | Overflow is architecturally undefined |

## Verification
With the default output register, every output belonging to a request is due in the cycle after the clock edge that samples `in_valid`. The driver stamps each expected item with the cycle count at which it drove the request. The monitor pops an item only when `out_valid` is high, sampling on the falling clock edge, and checks that exactly one cycle has passed since the stamp. Expected values come from a bit-at-a-time reference model in the bench, so carry and overflow are derived from single-bit steps rather than from the unit's barrel logic.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [1:0] {
    OP_SHL = 2'd0,
    OP_SAR = 2'd1,
    OP_ROR = 2'd2,
    OP_NOP = 2'd3
  } shrot_op_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } shrot_size_e;
endpackage

// File: rtl/shrot_count.sv
module shrot_count #(
  parameter int DATA_W  = 64,
  parameter int CNT_W   = 8,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [1:0]         size_sel,
  input  logic [CNT_W-1:0]   count,
  output logic [SHAMT_W-1:0] mcnt,
  output logic [SHAMT_W-1:0] msb_idx,
  output logic [DATA_W-1:0]  mask,
  output logic               cnt_zero,
  output logic               cnt_one
);
  import shrot_pkg::*;

  logic unused_cnt_hi;
  assign unused_cnt_hi = ^count[CNT_W-1:SHAMT_W];

  always_comb begin
    mcnt    = count[SHAMT_W-1:0];
    msb_idx = SHAMT_W'(DATA_W - 1);
    case (shrot_size_e'(size_sel))
      SZ_8:    begin mcnt[SHAMT_W-1] = 1'b0; msb_idx = SHAMT_W'(7);  end
      SZ_16:   begin mcnt[SHAMT_W-1] = 1'b0; msb_idx = SHAMT_W'(15); end
      SZ_32:   begin mcnt[SHAMT_W-1] = 1'b0; msb_idx = SHAMT_W'(31); end
      default: ;
    endcase
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      mask[i] = (i <= int'(msb_idx));
    end
  end

  assign cnt_zero = (mcnt == '0);
  assign cnt_one  = (mcnt == SHAMT_W'(1));
endmodule

// File: rtl/shrot_core.sv
module shrot_core #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [1:0]         op_sel,
  input  logic [DATA_W-1:0]  operand,
  input  logic [SHAMT_W-1:0] mcnt,
  input  logic [SHAMT_W-1:0] msb_idx,
  input  logic [DATA_W-1:0]  mask,
  output logic [DATA_W-1:0]  res,
  output logic               carry
);
  import shrot_pkg::*;

  logic [DATA_W-1:0]  a;
  logic [DATA_W-1:0]  sext;
  logic [DATA_W-1:0]  rot;
  logic [SHAMT_W:0]   wid;
  logic [SHAMT_W:0]   lsh;
  logic [SHAMT_W-1:0] ramt;

  assign a    = operand & mask;
  assign wid  = {1'b0, msb_idx} + 1'b1;
  assign ramt = mcnt & msb_idx;
  assign lsh  = wid - {1'b0, ramt};
  assign rot  = (a >> ramt) | (a << lsh);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      sext[i] = (i <= int'(msb_idx)) ? a[i] : a[msb_idx];
    end
  end

  always_comb begin
    res   = a;
    carry = 1'b0;
    case (shrot_op_e'(op_sel))
      OP_SHL: begin
        res = (a << mcnt) & mask;
        if ((mcnt != '0) && ({1'b0, mcnt} <= wid)) begin
          carry = a[SHAMT_W'(wid - {1'b0, mcnt})];
        end
      end
      OP_SAR: begin
        res = DATA_W'($signed(sext) >>> mcnt) & mask;
        if (mcnt != '0) begin
          carry = sext[mcnt - 1'b1];
        end
      end
      OP_ROR: begin
        res   = rot & mask;
        carry = rot[msb_idx];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags (
  input  logic [1:0] op_sel,
  input  logic       cnt_zero,
  input  logic       cnt_one,
  input  logic       carry,
  input  logic       res_top,
  input  logic       res_next,
  input  logic       prev_cf,
  input  logic       prev_of,
  output logic       cf,
  output logic       of,
  output logic       we,
  output logic       of_undef
);
  import shrot_pkg::*;

  always_comb begin
    we       = (shrot_op_e'(op_sel) != OP_NOP) && !cnt_zero;
    cf       = prev_cf;
    of       = prev_of;
    of_undef = 1'b0;
    if (we) begin
      cf = carry;
      if (cnt_one) begin
        case (shrot_op_e'(op_sel))
          OP_SHL:  of = carry ^ res_top;
          OP_SAR:  of = 1'b0;
          default: of = res_top ^ res_next;
        endcase
      end else begin
        of_undef = 1'b1;
      end
    end
  end
endmodule

// File: rtl/shrot_outreg.sv
module shrot_outreg #(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic [DATA_W-1:0] res_in,
  input  logic [3:0]        flg_in,
  output logic              v_out,
  output logic [DATA_W-1:0] res_out,
  output logic [3:0]        flg_out
);
  generate
    if (REG_OUT) begin : g_reg
      logic              v_q, v_d;
      logic [DATA_W-1:0] res_q, res_d;
      logic [3:0]        flg_q, flg_d;

      always_comb begin
        v_d   = v_in;
        res_d = res_q;
        flg_d = flg_q;
        if (v_in) begin
          res_d = res_in;
          flg_d = flg_in;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q   <= 1'b0;
          res_q <= '0;
          flg_q <= '0;
        end else begin
          v_q   <= v_d;
          res_q <= res_d;
          flg_q <= flg_d;
        end
      end

      assign v_out   = v_q;
      assign res_out = res_q;
      assign flg_out = flg_q;
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign v_out   = v_in;
      assign res_out = res_in;
      assign flg_out = flg_in;
    end
  endgenerate
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int DATA_W  = 64,
  parameter int CNT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [1:0]        size_sel,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic              prev_cf,
  input  logic              prev_of,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              cf_out,
  output logic              of_out,
  output logic              flag_we,
  output logic              of_undefined
);
  localparam int SHAMT_W = $clog2(DATA_W);

  logic [SHAMT_W-1:0] mcnt, msb_idx;
  logic [DATA_W-1:0]  mask, res;
  logic               cnt_zero, cnt_one, carry;
  logic               cf, of, we, of_undef;
  logic [3:0]         flg_q;

  shrot_count #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SHAMT_W(SHAMT_W)) u_count (
    .size_sel (size_sel),
    .count    (count),
    .mcnt     (mcnt),
    .msb_idx  (msb_idx),
    .mask     (mask),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one)
  );

  shrot_core #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_core (
    .op_sel  (op_sel),
    .operand (operand),
    .mcnt    (mcnt),
    .msb_idx (msb_idx),
    .mask    (mask),
    .res     (res),
    .carry   (carry)
  );

  shrot_flags u_flags (
    .op_sel   (op_sel),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one),
    .carry    (carry),
    .res_top  (res[msb_idx]),
    .res_next (res[msb_idx - 1'b1]),
    .prev_cf  (prev_cf),
    .prev_of  (prev_of),
    .cf       (cf),
    .of       (of),
    .we       (we),
    .of_undef (of_undef)
  );

  shrot_outreg #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_outreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .v_in    (in_valid),
    .res_in  (res),
    .flg_in  ({cf, of, we, of_undef}),
    .v_out   (out_valid),
    .res_out (result),
    .flg_out (flg_q)
  );

  assign {cf_out, of_out, flag_we, of_undefined} = flg_q;
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int DATA_W  = 64,
  parameter int CNT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op_sel,
  input logic [1:0]        size_sel,
  input logic [CNT_W-1:0]  count,
  input logic              prev_cf,
  input logic              prev_of,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              cf_out,
  input logic              of_out,
  input logic              flag_we,
  input logic              of_undefined
);
  function automatic int unsigned eff_cnt(input logic [1:0] sz, input logic [CNT_W-1:0] c);
    return (sz == 2'd3) ? int'(c[5:0]) : int'(c[4:0]);
  endfunction

  function automatic int unsigned top_bit(input logic [1:0] sz);
    return (8 << sz) - 1;
  endfunction

  function automatic logic [DATA_W-1:0] hi_part(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    return (sz == 2'd3) ? '0 : (v >> (8 << sz));
  endfunction

  generate
    if (REG_OUT) begin : g_props
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R13
      AST_NO_FLAG_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && eff_cnt(size_sel, count) == 0) |=>
          (!flag_we && !of_undefined && cf_out == $past(prev_cf) && of_out == $past(prev_of))); // R2
      AST_SAR_ONE_CLEARS_OF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd1 && eff_cnt(size_sel, count) == 1) |=> (flag_we && !of_out)); // R7
      AST_OF_UNDEF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 2'd3 && eff_cnt(size_sel, count) > 1) |=>
          (flag_we && of_undefined && of_out == $past(prev_of))); // R9
      AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (hi_part(result, $past(size_sel)) == '0)); // R10
      AST_ROR_CARRY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd2 && eff_cnt(size_sel, count) != 0) |=>
          (cf_out == result[top_bit($past(size_sel))])); // R5
      AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd3) |=> !flag_we); // R12
    end
  endgenerate

  AST_UNDEF_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    of_undefined |-> flag_we); // R9
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .op_sel       (op_sel),
  .size_sel     (size_sel),
  .count        (count),
  .prev_cf      (prev_cf),
  .prev_of      (prev_of),
  .out_valid    (out_valid),
  .result       (result),
  .cf_out       (cf_out),
  .of_out       (of_out),
  .flag_we      (flag_we),
  .of_undefined (of_undefined)
);

// File: tb/shrot_unit_bench.sv
`timescale 1ns/1ps
module shrot_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic [1:0]  size_sel;
  logic [63:0] operand;
  logic [7:0]  count;
  logic        prev_cf;
  logic        prev_of;
  logic        out_valid;
  logic [63:0] result;
  logic        cf_out, of_out, flag_we, of_undefined;

  typedef struct {
    logic [63:0] res;
    logic        cf;
    logic        of;
    logic        we;
    logic        undef;
    int          stamp;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   cyc     = 0;

  shrot_unit u_shrot_unit (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op_sel (op_sel),
    .size_sel (size_sel), .operand (operand), .count (count),
    .prev_cf (prev_cf), .prev_of (prev_of), .out_valid (out_valid),
    .result (result), .cf_out (cf_out), .of_out (of_out),
    .flag_we (flag_we), .of_undefined (of_undefined)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model: one bit per step, independent of any barrel structure.
  function automatic exp_t model(input logic [1:0] op, input logic [1:0] sz,
                                 input logic [63:0] x, input logic [7:0] c,
                                 input logic pcf, input logic pof);
    exp_t e;
    int w = 8 << sz;
    int n = (sz == 2'd3) ? int'(c & 8'd63) : int'(c & 8'd31);
    logic [63:0] m = '0;
    logic [63:0] a;
    logic cy = 1'b0;
    logic s;
    for (int i = 0; i < w; i++) m[i] = 1'b1;
    a = x & m;
    e.res = a; e.cf = pcf; e.of = pof; e.we = 1'b0; e.undef = 1'b0;
    e.stamp = 0; e.tag = "";
    if (op == 2'd3 || n == 0) return e;
    for (int k = 0; k < n; k++) begin
      case (op)
        2'd0: begin cy = a[w-1]; a = (a << 1) & m; end
        2'd1: begin cy = a[0]; s = a[w-1]; a = (a >> 1) | (64'(s) << (w-1)); end
        default: begin cy = a[0]; a = (a >> 1) | (64'(cy) << (w-1)); end
      endcase
    end
    e.res = a; e.cf = cy; e.we = 1'b1;
    if (n == 1) begin
      case (op)
        2'd0:    e.of = cy ^ a[w-1];
        2'd1:    e.of = 1'b0;
        default: e.of = a[w-1] ^ a[w-2];
      endcase
    end else begin
      e.undef = 1'b1;
    end
    return e;
  endfunction

  task automatic send(input logic [1:0] op, input logic [1:0] sz, input logic [63:0] x,
                      input logic [7:0] c, input logic pcf, input logic pof, input string tag);
    exp_t e;
    @(negedge clk);
    op_sel = op; size_sel = sz; operand = x; count = c;
    prev_cf = pcf; prev_of = pof; in_valid = 1'b1;
    e = model(op, sz, x, c, pcf, pof);
    e.stamp = cyc;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expected item per valid output.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R13: out_valid with no request pending, actual=1 expected=0");
      end else begin
        e = exp_q.pop_front();
        if (cyc != e.stamp + 1) begin
          n_fail++;
          $display("FAIL R13 [%s]: latency actual=%0d expected=1", e.tag, cyc - e.stamp);
        end else if (result !== e.res || cf_out !== e.cf || of_out !== e.of ||
                     flag_we !== e.we || of_undefined !== e.undef) begin
          n_fail++;
          $display("FAIL %s: actual res=%h cf=%b of=%b we=%b ud=%b expected res=%h cf=%b of=%b we=%b ud=%b",
                   e.tag, result, cf_out, of_out, flag_we, of_undefined,
                   e.res, e.cf, e.of, e.we, e.undef);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] lcg;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; size_sel = '0;
    operand = '0; count = '0; prev_cf = 1'b0; prev_of = 1'b0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || result !== '0 || cf_out !== 1'b0 || of_out !== 1'b0 ||
        flag_we !== 1'b0 || of_undefined !== 1'b0) begin
      n_fail++;
      $display("FAIL R13 reset: actual v=%b res=%h we=%b expected v=0 res=0 we=0",
               out_valid, result, flag_we);
    end
    rst_n = 1'b1;
    idle(2);

    // R3 / R6: left shift by one at two widths
    send(2'd0, 2'd0, 64'h81, 8'd1, 1'b0, 1'b0, "R3 R6 shl8 by1");
    send(2'd0, 2'd1, 64'h4000, 8'd1, 1'b1, 1'b0, "R3 R6 shl16 by1");
    send(2'd0, 2'd2, 64'h0000_0000_F000_0001, 8'd4, 1'b0, 1'b1, "R3 shl32 by4");
    // R4: signed example and carry
    send(2'd1, 2'd2, 64'hFFFF_FFF5, 8'd2, 1'b0, 1'b0, "R4 sar -11 by2");
    send(2'd1, 2'd3, 64'h8000_0000_0000_0003, 8'd2, 1'b0, 1'b1, "R4 sar64 by2");
    // R7
    send(2'd1, 2'd0, 64'h80, 8'd1, 1'b0, 1'b1, "R7 sar8 by1 clears of");
    send(2'd1, 2'd1, 64'h0003, 8'd1, 1'b0, 1'b1, "R7 sar16 by1 positive");
    // R8
    send(2'd2, 2'd0, 64'h01, 8'd1, 1'b0, 1'b0, "R8 ror8 by1");
    send(2'd2, 2'd3, 64'h3, 8'd1, 1'b0, 1'b0, "R8 ror64 by1");
    // R5
    send(2'd2, 2'd3, 64'h0123_4567_89AB_CDEF, 8'd4, 1'b0, 1'b0, "R5 ror64 by4");
    send(2'd2, 2'd0, 64'h96, 8'd12, 1'b0, 1'b1, "R5 ror8 by12 mod");
    send(2'd2, 2'd0, 64'h96, 8'd8, 1'b1, 1'b0, "R5 ror8 by8 writes flags");
    // R1
    send(2'd0, 2'd2, 64'h1, 8'h21, 1'b0, 1'b0, "R1 size32 count 0x21");
    send(2'd1, 2'd3, 64'hF0, 8'h44, 1'b0, 1'b0, "R1 size64 count 0x44");
    send(2'd0, 2'd3, 64'h1, 8'd40, 1'b0, 1'b1, "R1 size64 count 40");
    // R2
    send(2'd0, 2'd0, 64'hAB, 8'h20, 1'b1, 1'b1, "R2 size8 count 0x20 zero");
    send(2'd2, 2'd3, 64'hDEAD_BEEF_0000_0001, 8'h40, 1'b0, 1'b1, "R2 size64 count 0x40");
    send(2'd1, 2'd1, 64'h8000, 8'd0, 1'b1, 1'b0, "R2 count 0");
    // R10
    send(2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_8001, 8'd1, 1'b0, 1'b0, "R10 upper bits dropped");
    // R11
    send(2'd0, 2'd0, 64'h81, 8'd8, 1'b0, 1'b0, "R11 shl8 by8");
    send(2'd0, 2'd0, 64'hFF, 8'd9, 1'b1, 1'b0, "R11 shl8 by9");
    send(2'd1, 2'd1, 64'h8001, 8'd20, 1'b0, 1'b0, "R11 sar16 by20");
    // R9
    send(2'd0, 2'd2, 64'h5, 8'd3, 1'b0, 1'b1, "R9 of held 1");
    send(2'd2, 2'd2, 64'h5, 8'd3, 1'b1, 1'b0, "R9 of held 0");
    // R12
    send(2'd3, 2'd0, 64'h1234, 8'd3, 1'b1, 1'b0, "R12 nop");
    idle(1);
    // R13: idle cycle must not raise out_valid
    @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R13 idle: actual out_valid=%b expected=0", out_valid);
    end

    lcg = 64'h0F1E_2D3C_4B5A_6978;
    for (int i = 0; i < 60; i++) begin
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      send(2'(lcg[63:62] % 3), lcg[61:60], lcg ^ (lcg << 17), lcg[15:8], lcg[20], lcg[21],
           "R3 R4 R5 mixed");
    end
    idle(4);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R13 drain: actual pending=%0d expected=0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule